// File: doc/BRIEF.md
# Interval Timer with Programmable Interrupt Vector

This block is a periodic interrupt timer on a small 32-bit register port. Software stores a reload value, then sets an enable bit in a configuration word. That word also carries the trap number and priority the timer should signal. While the timer runs, a down-counter advances once per bus clock. Each time the counter expires, the block sends a one-cycle interrupt request to an interrupt controller, with a vector and priority beside it. The counter then reloads and goes on. A single-event delay is made by software clearing the enable bit in the first interrupt handler.

The trap number is not wired to a fixed line: the interrupt controller receives whatever the configuration word holds. A build-time parameter picks one of two vector mappings. The first passes the full 8-bit trap through unchanged. The second restricts the vector to the range 64..127 and folds the priority into the vector's low bits. Two read-only registers let software observe the running count and learn the bus clock period in nanoseconds.

Top module: `irq_interval_timer`

## Requirements
- R1: After reset the timer is stopped, no interrupt request is raised, and the configuration, reload and count registers read 0.
- R2: A write to offset 0x00 with bit 26 set, while the timer is stopped, starts it. The count register reads the reload value on the cycle after that write. The first request appears exactly reload-value cycles after the write edge.
- R3: While running, the timer raises `irqReq` for exactly one cycle every reload-value cycles and reloads the count from the reload register at each expiry.
- R4: A write to offset 0x00 with bit 26 clear stops the timer at once. No request follows it, even if the count would have expired on that same edge.
- R5: Offset 0x14 reads the current count, which falls by one per cycle while running and reads 0 whenever the timer is stopped.
- R6: A write to offset 0x10 only latches a new reload value. It does not start a stopped timer. In a running timer it takes effect at the next expiry, not before.
- R7: With the restricted mapping (parameter `LEGACY_MAP` = 0), the vector is 64 + (trap[5:0] OR (priority × 4)). The top two trap bits are ignored.
- R8: With the legacy mapping (`LEGACY_MAP` = 1), the vector equals the full 8-bit trap field. In both mappings `irqPrio` equals the 4-bit priority field.
- R9: A reload value of 0 behaves as 1: the timer fires on every cycle.
- R10: The configuration register lays out its fields as follows:
  - bit 26: enable
  - bits 23:20: priority
  - bits 19:12: trap number
  - all other bits: read as 0

  Offset 0x10 reads back the reload value. Offset 0x18 reads the `BUS_PERIOD_NS` parameter. Writes to 0x14 and 0x18 have no effect.
- R11: Rewriting offset 0x00 with bit 26 set while the timer is already running does not restart the count.
- R12: `irqVector` and `irqPrio` are 0 on every cycle without a request and hold the mapped values on the request cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; the counter advances once per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe for the current cycle |
| addr | input | 8 | Register byte offset for both reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, combinational |
| irqReq | output | 1 | One-cycle interrupt request at each expiry |
| irqVector | output | 8 | Trap vector that goes with the request |
| irqPrio | output | 4 | Priority that goes with the request |

## Verification
The bench runs two copies of the timer side by side, one built with each mapping. Every expected request is queued with its exact cycle, vector and priority. This exposes off-by-one timing and mapping errors separately.

The periodic pattern uses reload 5 and changes the reload to 3 mid-run, which tells a reload that takes effect at expiry from one that takes effect at once. A reload of 0 tells the fire-every-cycle rule from a counter that hangs. The trap values are 0xC5, 0x3F and 0x80, each paired with a different priority. They distinguish ignoring the upper trap bits from keeping them, and OR-ing in the priority from leaving it out.

A disable write placed on the very edge of a pending expiry separates a stop that wins from one that lets a last request through. A repeated enable write in mid-count separates a start edge from a level-triggered restart.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

  localparam int REG_W    = 32;
  localparam int EN_BIT   = 26;
  localparam int TRAP_LSB = 12;
  localparam int TRAP_W   = 8;
  localparam int PRIO_LSB = 20;
  localparam int PRIO_W   = 4;

  localparam int OFF_CFG    = 'h00;
  localparam int OFF_RELOAD = 'h10;
  localparam int OFF_COUNT  = 'h14;
  localparam int OFF_PERIOD = 'h18;

  typedef struct packed {
    logic startRun;
    logic stopRun;
    logic cfgWr;
    logic reloadWr;
  } itmr_strobe_t;

endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int BUS_PERIOD_NS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                enReq,
  input  logic [TRAP_W-1:0]   cfgTrap,
  input  logic [PRIO_W-1:0]   cfgPrio,
  input  logic [REG_W-1:0]    reloadVal,
  input  logic [REG_W-1:0]    countVal,
  output itmr_strobe_t        strobe,
  output logic                running,
  output logic [REG_W-1:0]    rdData
);

  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_PERIOD = ADDR_W'(OFF_PERIOD);

  logic cfgHit;

  always_comb begin
    cfgHit          = wrEn && (addr == A_CFG);
    strobe.cfgWr    = cfgHit;
    strobe.startRun = cfgHit && enReq && !running;
    strobe.stopRun  = cfgHit && !enReq;
    strobe.reloadWr = wrEn && (addr == A_RELOAD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
    end else if (strobe.startRun) begin
      running <= 1'b1;
    end else if (strobe.stopRun) begin
      running <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CFG: begin
        rdData[EN_BIT]                     = running;
        rdData[PRIO_LSB +: PRIO_W]         = cfgPrio;
        rdData[TRAP_LSB +: TRAP_W]         = cfgTrap;
      end
      A_RELOAD: rdData = reloadVal;
      A_COUNT:  rdData = countVal;
      A_PERIOD: rdData = REG_W'(BUS_PERIOD_NS);
      default:  rdData = '0;
    endcase
  end

  AST_STOP_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(running) |-> $past(wrEn && addr == A_CFG && !enReq)); // R4

  AST_START_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> $past(wrEn && addr == A_CFG && enReq)); // R6

endmodule

// File: rtl/itmr_datapath.sv
module itmr_datapath
  import itmr_pkg::*;
#(
  parameter bit LEGACY_MAP = 1'b0
) (
  input  logic                clk,
  input  logic                rstN,
  input  itmr_strobe_t        strobe,
  input  logic                running,
  input  logic [REG_W-1:0]    wrData,
  output logic [REG_W-1:0]    reloadVal,
  output logic [REG_W-1:0]    countVal,
  output logic [TRAP_W-1:0]   cfgTrap,
  output logic [PRIO_W-1:0]   cfgPrio,
  output logic                irqReq,
  output logic [TRAP_W-1:0]   irqVector,
  output logic [PRIO_W-1:0]   irqPrio
);

  logic [REG_W-1:0]  reloadEff;
  logic              fire;
  logic [TRAP_W-1:0] mappedVec;

  assign reloadEff = (reloadVal == '0) ? REG_W'(1) : reloadVal;
  assign fire      = running && !strobe.stopRun && (countVal == REG_W'(1));

  generate
    if (LEGACY_MAP) begin : g_legacy
      assign mappedVec = cfgTrap;
    end else begin : g_window
      assign mappedVec = {2'b01, cfgTrap[5:0] | {cfgPrio, 2'b00}};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadVal <= '0;
      cfgTrap   <= '0;
      cfgPrio   <= '0;
    end else begin
      if (strobe.reloadWr) reloadVal <= wrData;
      if (strobe.cfgWr) begin
        cfgTrap <= wrData[TRAP_LSB +: TRAP_W];
        cfgPrio <= wrData[PRIO_LSB +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobe.stopRun) begin
      countVal <= '0;
    end else if (strobe.startRun) begin
      countVal <= reloadEff;
    end else if (running) begin
      countVal <= (countVal <= REG_W'(1)) ? reloadEff : countVal - REG_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReq    <= 1'b0;
      irqVector <= '0;
      irqPrio   <= '0;
    end else begin
      irqReq    <= fire;
      irqVector <= fire ? mappedVec : '0;
      irqPrio   <= fire ? cfgPrio : '0;
    end
  end

  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> countVal == '0); // R5

  AST_RUN_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    running |-> countVal != '0); // R9

  AST_REQ_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> running); // R4

  AST_START_LOADS_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> countVal == ((reloadVal == '0) ? REG_W'(1) : reloadVal)); // R2

  AST_QUIET_SIDEBAND: assert property (@(posedge clk) disable iff (!rstN)
    !irqReq |-> (irqVector == '0 && irqPrio == '0)); // R12

  generate
    if (!LEGACY_MAP) begin : g_chk_window
      AST_VECTOR_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
        irqReq |-> irqVector[7:6] == 2'b01); // R7
    end
  endgenerate

endmodule

// File: rtl/irq_interval_timer.sv
module irq_interval_timer
  import itmr_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int BUS_PERIOD_NS = 8,
  parameter bit LEGACY_MAP    = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              irqReq,
  output logic [7:0]        irqVector,
  output logic [3:0]        irqPrio
);

  itmr_strobe_t      strobe;
  logic              running;
  logic [REG_W-1:0]  reloadVal;
  logic [REG_W-1:0]  countVal;
  logic [TRAP_W-1:0] cfgTrap;
  logic [PRIO_W-1:0] cfgPrio;

  itmr_ctrl #(
    .ADDR_W        (ADDR_W),
    .BUS_PERIOD_NS (BUS_PERIOD_NS)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .addr      (addr),
    .enReq     (wrData[EN_BIT]),
    .cfgTrap   (cfgTrap),
    .cfgPrio   (cfgPrio),
    .reloadVal (reloadVal),
    .countVal  (countVal),
    .strobe    (strobe),
    .running   (running),
    .rdData    (rdData)
  );

  itmr_datapath #(
    .LEGACY_MAP (LEGACY_MAP)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .running   (running),
    .wrData    (wrData),
    .reloadVal (reloadVal),
    .countVal  (countVal),
    .cfgTrap   (cfgTrap),
    .cfgPrio   (cfgPrio),
    .irqReq    (irqReq),
    .irqVector (irqVector),
    .irqPrio   (irqPrio)
  );

endmodule

// File: tb/tb_irq_interval_timer.sv
module tb_irq_interval_timer;

  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData, rdDataL;
  logic        irqReq, irqReqL;
  logic [7:0]  irqVector, irqVectorL;
  logic [3:0]  irqPrio, irqPrioL;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int         at;
    logic [7:0] vec;
    logic [3:0] prio;
  } exp_t;

  exp_t qWin[$];
  exp_t qLeg[$];

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  irq_interval_timer #(.LEGACY_MAP(1'b0)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqReq(irqReq), .irqVector(irqVector), .irqPrio(irqPrio));

  irq_interval_timer #(.LEGACY_MAP(1'b1)) dutLegacy (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdDataL), .irqReq(irqReqL), .irqVector(irqVectorL), .irqPrio(irqPrioL));

  function automatic logic [31:0] cfgWord(bit en, logic [7:0] trap, logic [3:0] prio);
    return (32'(en) << 26) | (32'(prio) << 20) | (32'(trap) << 12);
  endfunction

  // R7 / R8: expected vectors for both mappings
  function automatic void pushReq(int at, logic [7:0] trap, logic [3:0] prio);
    exp_t w, l;
    w.at = at; w.prio = prio;
    w.vec = 8'd64 + {2'b00, trap[5:0] | {prio, 2'b00}};
    l.at = at; l.prio = prio; l.vec = trap;
    qWin.push_back(w);
    qLeg.push_back(l);
  endfunction

  // scoreboard monitor, restricted mapping
  always @(negedge clk) begin
    if (rstN && !done) begin
      while (qWin.size() > 0 && qWin[0].at < cyc) begin
        checks++; failures++;
        $display("FAIL R3 window: missed request, actual none expected cyc=%0d", qWin[0].at);
        void'(qWin.pop_front());
      end
      if (irqReq) begin
        checks++;
        if (qWin.size() == 0 || qWin[0].at != cyc) begin
          failures++;
          $display("FAIL R4 window: unexpected request actual cyc=%0d expected none", cyc);
        end else begin
          exp_t e;
          e = qWin.pop_front();
          if (irqVector !== e.vec || irqPrio !== e.prio) begin
            failures++;
            $display("FAIL R7 vector/prio actual %02h/%0h expected %02h/%0h",
                     irqVector, irqPrio, e.vec, e.prio);
          end
        end
      end
    end
  end

  // scoreboard monitor, legacy mapping
  always @(negedge clk) begin
    if (rstN && !done) begin
      while (qLeg.size() > 0 && qLeg[0].at < cyc) begin
        checks++; failures++;
        $display("FAIL R3 legacy: missed request, actual none expected cyc=%0d", qLeg[0].at);
        void'(qLeg.pop_front());
      end
      if (irqReqL) begin
        checks++;
        if (qLeg.size() == 0 || qLeg[0].at != cyc) begin
          failures++;
          $display("FAIL R4 legacy: unexpected request actual cyc=%0d expected none", cyc);
        end else begin
          exp_t e;
          e = qLeg.pop_front();
          if (irqVectorL !== e.vec || irqPrioL !== e.prio) begin
            failures++;
            $display("FAIL R8 vector/prio actual %02h/%0h expected %02h/%0h",
                     irqVectorL, irqPrioL, e.vec, e.prio);
          end
        end
      end
    end
  end

  task automatic checkVal(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  // call at a falling edge; the write lands on the next rising edge
  task automatic busWrite(logic [7:0] a, logic [31:0] d, output int edgeCyc);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    edgeCyc = cyc;
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finishRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    logic [31:0] d;
    int e, w;
    logic [31:0] wordA;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkVal("R1 irqReq after reset", 32'(irqReq), 0);
    busRead(8'h00, d); checkVal("R1 cfg after reset", d, 0);
    busRead(8'h10, d); checkVal("R1 reload after reset", d, 0);
    busRead(8'h14, d); checkVal("R1 count after reset", d, 0);
    busRead(8'h18, d); checkVal("R10 bus period", d, 8);

    // R10 writes to read-only offsets ignored
    busWrite(8'h14, 32'h1234, e);
    busWrite(8'h18, 32'h55, e);
    busRead(8'h14, d); checkVal("R10 count write ignored", d, 0);
    busRead(8'h18, d); checkVal("R10 period write ignored", d, 8);

    // R6 reload latched while stopped, no start
    busWrite(8'h10, 32'd5, e);
    busRead(8'h10, d); checkVal("R10 reload readback", d, 5);
    waitUntil(e + 6);
    busRead(8'h14, d); checkVal("R6 reload write does not start", d, 0);

    // periodic run, reload 5
    wordA = cfgWord(1, 8'hC5, 4'hA);
    busWrite(8'h00, wordA, w);
    pushReq(w + 5,  8'hC5, 4'hA);
    pushReq(w + 10, 8'hC5, 4'hA);
    pushReq(w + 15, 8'hC5, 4'hA);
    pushReq(w + 18, 8'hC5, 4'hA);
    pushReq(w + 21, 8'hC5, 4'hA);
    busRead(8'h14, d); checkVal("R2 count loaded at start", d, 5);
    busRead(8'h00, d); checkVal("R10 cfg readback", d, wordA);
    waitUntil(w + 1);
    busRead(8'h14, d); checkVal("R5 count decrements", d, 4);
    busWrite(8'h00, wordA, e);
    busRead(8'h14, d); checkVal("R11 rewrite keeps count", d, 3);
    waitUntil(w + 5);
    busRead(8'h14, d); checkVal("R3 count reloaded on expiry", d, 5);
    waitUntil(w + 11);
    busWrite(8'h10, 32'd3, e);
    busRead(8'h14, d); checkVal("R6 running reload not applied early", d, 3);
    waitUntil(w + 23);
    busWrite(8'h00, 32'd0, e);  // lands on the edge of a pending expiry
    busRead(8'h14, d); checkVal("R5 count zero when stopped", d, 0);
    busRead(8'h00, d); checkVal("R4 cfg cleared", d, 0);
    waitUntil(w + 40);
    checkVal("R4 no pending requests after stop", 32'(qWin.size() + qLeg.size()), 0);

    // R9 reload zero fires every cycle
    busWrite(8'h10, 32'd0, e);
    busRead(8'h14, d); checkVal("R5 count zero before start", d, 0);
    busWrite(8'h00, cfgWord(1, 8'h3F, 4'h0), w);
    pushReq(w + 1, 8'h3F, 4'h0);
    pushReq(w + 2, 8'h3F, 4'h0);
    pushReq(w + 3, 8'h3F, 4'h0);
    busRead(8'h14, d); checkVal("R9 zero reload counts as one", d, 1);
    waitUntil(w + 3);
    busWrite(8'h00, 32'd0, e);
    waitUntil(w + 12);

    // R7 top trap bits ignored, priority folded in
    busWrite(8'h10, 32'd2, e);
    busWrite(8'h00, cfgWord(1, 8'h80, 4'hF), w);
    pushReq(w + 2, 8'h80, 4'hF);
    pushReq(w + 4, 8'h80, 4'hF);
    waitUntil(w + 4);
    busWrite(8'h00, 32'd0, e);
    waitUntil(w + 14);

    checkVal("R3 all expected requests seen", 32'(qWin.size() + qLeg.size()), 0);
    finishRun();
  end

endmodule